// File: doc/BRIEF.md
# Masked interrupt flag controller

This block gathers eight interrupt sources of a small 8-bit microcontroller into a sticky pending-flag register. Five of the sources arrive as single-cycle event pulses: timer overflow, ADC conversion done and three PWM period matches. Three arrive as raw levels: an external interrupt pin, an 8-bit input port and a comparator output. Each raw level passes through a two-flop synchronizer. The block then detects a falling edge on the pin, any change on the port, and any transition on the comparator.

Software reaches the block through a small register bus. The pending register reads back only the flags that the mask register enables. A write to the pending register can clear flags but can never set them. A global enable, set and cleared by strobes from the instruction decoder, gates the interrupt request. A separate wake-enable register selects which of ADC done, comparator change and port change raise a wake request to the sleep controller. The wake request ignores both the mask and the global enable.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the pending flags, the mask, the wake-enable bits and the global enable are all 0, and irq_o and wake_o are low.
- R2: Pending flag positions are: bit 7 comparator change, bit 6 PWM3 match, bit 5 PWM2 match, bit 4 PWM1 match, bit 3 ADC done, bit 2 external pin, bit 1 port change, bit 0 timer overflow. An event pulse that is high at a clock edge sets its flag at that edge, whatever the mask holds. pwm_match_i bit 0 is PWM1.
- R3: A read at address 0 returns the pending flags ANDed with the mask. Address 1 is the mask register, readable and writable, with the same bit order. A 1 in a mask bit enables that source.
- R4: A write at address 0 leaves each flag as old flag AND written bit. Writing 0 clears a flag, and writing 1 leaves it unchanged, so a write never sets a flag.
- R5: When an event and a software clear reach the same flag in the same cycle, the flag ends up set.
- R6: A falling edge on ext_pin_i sets flag bit 2 on the third rising clock edge after the change. A rising edge sets nothing.
- R7: A change in any bit of port_i sets flag bit 1, and any transition of cmp_i sets flag bit 7, on the third rising edge after the change. All synchronizer stages reset to 0, so a nonzero level present after reset counts as a change.
- R8: eni_i sets the global enable and disi_i clears it, with disi_i winning when both are high. irq_o is high exactly when the global enable is set and at least one flag is both pending and unmasked.
- R9: Address 2 is the wake-enable register: bit 3 ADC done, bit 2 comparator change, bit 1 port change. Bits 7..4 and bit 0 ignore writes and read as 0. Address 3 reads as 0.
- R10: wake_o is high in each cycle in which a wake-enabled source has its event: the adc_done_i pulse itself, or the detected comparator or port change, one cycle before the matching flag sets. wake_o does not depend on the mask or the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 pending, 1 mask, 2 wake enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| adc_done_i | input | 1 | ADC conversion done event pulse |
| pwm_match_i | input | 3 | PWM period match pulses, bit 0 is PWM1 |
| ext_pin_i | input | 1 | External interrupt pin, raw level |
| port_i | input | 8 | Wake-capable input port, raw levels |
| cmp_i | input | 1 | Comparator output, raw level |
| eni_i | input | 1 | Enable-interrupt strobe |
| disi_i | input | 1 | Disable-interrupt strobe |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request to the sleep controller |

## Verification
The checker runs on every cycle. It checks that a flag rises only when an event fed it, that an event always survives a same-cycle clear, that a disable strobe drops the request and an enable strobe raises it when an unmasked flag is pending, that a masked read never shows a masked bit, that the unimplemented wake-enable bits read 0, and that wake_o stays low while no wake source is enabled. Only the directed scenarios can show the three-edge latency through the synchronizers, that a falling edge sets the pin flag while a rising edge does not, the exact bit order of the flags, and that wake_o ignores the mask and the global enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned NUM_PWM  = 3;

  localparam int unsigned B_TMR  = 0;
  localparam int unsigned B_PORT = 1;
  localparam int unsigned B_EXT  = 2;
  localparam int unsigned B_ADC  = 3;
  localparam int unsigned B_PWM1 = 4;
  localparam int unsigned B_CMP  = 7;

  localparam logic [ADDR_W-1:0] A_PEND = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_WAKE = 2'd2;
endpackage

// File: rtl/irq_level_det.sv
module irq_level_det #(
  parameter int unsigned WIDTH     = 1,
  parameter bit          FALL_ONLY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic             evt_o
);
  logic [WIDTH-1:0] s1_q, s2_q, prev_q;
  logic [WIDTH-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  generate
    if (FALL_ONLY) begin : g_fall
      assign hit = prev_q & ~s2_q;
    end else begin : g_any
      assign hit = prev_q ^ s2_q;
    end
  endgenerate

  assign evt_o = |hit;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_keep_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else if (clr_we_i) flag_q <= (flag_q & clr_keep_i) | set_i;
    else flag_q <= flag_q | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_wake_gen.sv
module irq_wake_gen (
  input  logic       adc_evt_i,
  input  logic       cmp_evt_i,
  input  logic       port_evt_i,
  input  logic [2:0] wake_en_i, // [2] adc, [1] cmp, [0] port
  output logic       wake_o
);
  assign wake_o = (wake_en_i[2] & adc_evt_i) |
                  (wake_en_i[1] & cmp_evt_i) |
                  (wake_en_i[0] & port_evt_i);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              adc_done_i,
  input  logic [NUM_PWM-1:0] pwm_match_i,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              cmp_i,
  input  logic              eni_i,
  input  logic              disi_i,
  output logic              irq_o,
  output logic              wake_o
);
  logic               ext_evt, port_evt, cmp_evt;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [2:0]         wake_en_q;
  logic               gie_q;

  irq_level_det #(.WIDTH(1), .FALL_ONLY(1'b1)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(ext_pin_i), .evt_o(ext_evt));
  irq_level_det #(.WIDTH(PORT_W), .FALL_ONLY(1'b0)) u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(port_i), .evt_o(port_evt));
  irq_level_det #(.WIDTH(1), .FALL_ONLY(1'b0)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(cmp_i), .evt_o(cmp_evt));

  always_comb begin
    set_vec         = '0;
    set_vec[B_TMR]  = tmr_ovf_i;
    set_vec[B_PORT] = port_evt;
    set_vec[B_EXT]  = ext_evt;
    set_vec[B_ADC]  = adc_done_i;
    set_vec[B_CMP]  = cmp_evt;
    for (int i = 0; i < NUM_PWM; i++) set_vec[B_PWM1+i] = pwm_match_i[i];
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
    .clr_we_i(reg_we_i && reg_addr_i == A_PEND),
    .clr_keep_i(reg_wdata_i[NUM_SRC-1:0]), .flag_o(flag_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      wake_en_q <= '0;
      gie_q     <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_we_i && reg_addr_i == A_WAKE) wake_en_q <= reg_wdata_i[3:1];
      if (disi_i) gie_q <= 1'b0;
      else if (eni_i) gie_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_PEND:  reg_rdata_o = flag_q & mask_q;
      A_MASK:  reg_rdata_o = mask_q;
      A_WAKE:  reg_rdata_o = {4'b0, wake_en_q, 1'b0};
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = gie_q & |(flag_q & mask_q);

  irq_wake_gen u_wake (
    .adc_evt_i(adc_done_i), .cmp_evt_i(cmp_evt), .port_evt_i(port_evt),
    .wake_en_i(wake_en_q), .wake_o(wake_o));
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] reg_addr_i,
  input logic       reg_we_i,
  input logic [7:0] reg_rdata_o,
  input logic       eni_i,
  input logic       disi_i,
  input logic       irq_o,
  input logic       wake_o,
  input logic [7:0] flag_q,
  input logic [7:0] mask_q,
  input logic [7:0] set_vec,
  input logic [2:0] wake_en_q
);
  a_r4_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == 8'h00));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != 8'h00) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  a_r8_disi_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disi_i |=> !irq_o);

  a_r8_eni_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eni_i && !disi_i && !reg_we_i && |(flag_q & mask_q)) |=> irq_o);

  a_r3_read_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> ((reg_rdata_o & ~mask_q) == 8'h00));

  a_r9_wake_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd2) |-> (reg_rdata_o[7:4] == 4'h0 && !reg_rdata_o[0]));

  a_r10_wake_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_en_q == 3'b000) |-> !wake_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
  .reg_we_i(reg_we_i), .reg_rdata_o(reg_rdata_o), .eni_i(eni_i),
  .disi_i(disi_i), .irq_o(irq_o), .wake_o(wake_o), .flag_q(flag_q),
  .mask_q(mask_q), .set_vec(set_vec), .wake_en_q(wake_en_q));

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       tmr_ovf_i = 1'b0, adc_done_i = 1'b0;
  logic [2:0] pwm_match_i = '0;
  logic       ext_pin_i = 1'b0;
  logic [7:0] port_i = '0;
  logic       cmp_i = 1'b0;
  logic       eni_i = 1'b0, disi_i = 1'b0;
  logic       irq_o, wake_o;

  int tests_run = 0;
  int tests_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_flag_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .tmr_ovf_i(tmr_ovf_i), .adc_done_i(adc_done_i), .pwm_match_i(pwm_match_i),
    .ext_pin_i(ext_pin_i), .port_i(port_i), .cmp_i(cmp_i),
    .eni_i(eni_i), .disi_i(disi_i), .irq_o(irq_o), .wake_o(wake_o));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk_i);
    wr(2'd1, 8'hFF);
    rd(2'd0, d); chk("R1 pending after reset", d, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R1 mask cleared", d, 8'h00);
    rd(2'd2, d); chk("R1 wake enable after reset", d, 8'h00);
    chk("R1 irq_o low", {7'b0, irq_o}, 8'h00);
    chk("R1 wake_o low", {7'b0, wake_o}, 8'h00);
  endtask

  task automatic t_pulses();
    logic [7:0] d;
    // mask 0 while events fire
    @(negedge clk_i); tmr_ovf_i = 1'b1;
    @(negedge clk_i); tmr_ovf_i = 1'b0; adc_done_i = 1'b1;
    @(negedge clk_i); adc_done_i = 1'b0; pwm_match_i = 3'b101;
    @(negedge clk_i); pwm_match_i = 3'b000;
    wr(2'd1, 8'hFF);
    rd(2'd0, d); chk("R2 pulse flags set while masked", d, 8'h59);
    wr(2'd0, 8'h00);
    @(negedge clk_i); pwm_match_i = 3'b010;
    @(negedge clk_i); pwm_match_i = 3'b000;
    rd(2'd0, d); chk("R2 PWM2 at bit 5", d, 8'h20);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_mask_read();
    logic [7:0] d;
    @(negedge clk_i); tmr_ovf_i = 1'b1; adc_done_i = 1'b1; pwm_match_i = 3'b111;
    @(negedge clk_i); tmr_ovf_i = 1'b0; adc_done_i = 1'b0; pwm_match_i = 3'b000;
    wr(2'd1, 8'h3C);
    rd(2'd1, d); chk("R3 mask readback", d, 8'h3C);
    rd(2'd0, d); chk("R3 pending read is flag AND mask", d, 8'h38);
    wr(2'd1, 8'hFF);
    rd(2'd0, d); chk("R3 full mask shows all", d, 8'h79);
  endtask

  task automatic t_sw_clear();
    logic [7:0] d;
    wr(2'd0, 8'hF6); // clears bits 0 and 3
    rd(2'd0, d); chk("R4 zero bits clear flags", d, 8'h70);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R4 ones do not set flags", d, 8'h70);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R4 all cleared", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk_i);
    reg_addr_i = 2'd0; reg_wdata_i = 8'h00; reg_we_i = 1'b1; tmr_ovf_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; tmr_ovf_i = 1'b0;
    rd(2'd0, d); chk("R5 set wins over clear", d, 8'h01);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ext_pin();
    logic [7:0] d;
    @(negedge clk_i); ext_pin_i = 1'b1;
    cyc(4);
    rd(2'd0, d); chk("R6 rising edge sets nothing", d, 8'h00);
    ext_pin_i = 1'b0;
    cyc(2);
    rd(2'd0, d); chk("R6 not yet after two edges", d, 8'h00);
    cyc(1);
    rd(2'd0, d); chk("R6 falling edge sets bit 2 on third edge", d, 8'h04);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_port_cmp();
    logic [7:0] d;
    @(negedge clk_i); port_i = 8'h40;
    cyc(3);
    rd(2'd0, d); chk("R7 port bit change sets bit 1", d, 8'h02);
    wr(2'd0, 8'h00);
    cyc(3);
    rd(2'd0, d); chk("R7 steady port sets nothing", d, 8'h00);
    @(negedge clk_i); port_i = 8'h00;
    cyc(3);
    rd(2'd0, d); chk("R7 port return change sets bit 1", d, 8'h02);
    wr(2'd0, 8'h00);
    @(negedge clk_i); cmp_i = 1'b1;
    cyc(3);
    rd(2'd0, d); chk("R7 comparator rise sets bit 7", d, 8'h80);
    wr(2'd0, 8'h00);
    @(negedge clk_i); cmp_i = 1'b0;
    cyc(3);
    rd(2'd0, d); chk("R7 comparator fall sets bit 7", d, 8'h80);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_gie();
    @(negedge clk_i); tmr_ovf_i = 1'b1;
    @(negedge clk_i); tmr_ovf_i = 1'b0;
    #1 chk("R8 no irq without global enable", {7'b0, irq_o}, 8'h00);
    @(negedge clk_i); eni_i = 1'b1;
    @(negedge clk_i); eni_i = 1'b0;
    #1 chk("R8 irq after enable strobe", {7'b0, irq_o}, 8'h01);
    wr(2'd1, 8'hFE);
    #1 chk("R8 masked flag gives no irq", {7'b0, irq_o}, 8'h00);
    wr(2'd1, 8'hFF);
    @(negedge clk_i); eni_i = 1'b1; disi_i = 1'b1;
    @(negedge clk_i); eni_i = 1'b0; disi_i = 1'b0;
    #1 chk("R8 disable wins over enable", {7'b0, irq_o}, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_wake_reg();
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R9 only bits 3..1 implemented", d, 8'h0E);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R9 wake enable cleared", d, 8'h00);
    rd(2'd3, d); chk("R9 address 3 reads 0", d, 8'h00);
  endtask

  task automatic t_wake();
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h02); // port only; gie 0, mask 0
    @(negedge clk_i); port_i = 8'h01;
    cyc(2);
    #1 chk("R10 port change wakes with mask and gie off", {7'b0, wake_o}, 8'h01);
    cyc(1);
    #1 chk("R10 wake is one cycle", {7'b0, wake_o}, 8'h00);
    @(negedge clk_i); cmp_i = 1'b1;
    cyc(2);
    #1 chk("R10 comparator not enabled: no wake", {7'b0, wake_o}, 8'h00);
    wr(2'd2, 8'h08);
    @(negedge clk_i); adc_done_i = 1'b1;
    #1 chk("R10 ADC done wakes in its cycle", {7'b0, wake_o}, 8'h01);
    @(negedge clk_i); adc_done_i = 1'b0;
    wr(2'd2, 8'h04);
    @(negedge clk_i); cmp_i = 1'b0;
    cyc(2);
    #1 chk("R10 comparator change wakes", {7'b0, wake_o}, 8'h01);
    cyc(1);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  endtask

  initial begin
    #20000000;
    tests_run++;
    tests_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pulses();
    t_mask_read();
    t_sw_clear();
    t_set_wins();
    t_ext_pin();
    t_port_cmp();
    t_gie();
    t_wake_reg();
    t_wake();
    finish_run();
  end
endmodule